// File: doc/BRIEF.md
# Shift-Chain Upset Detector

The block pushes a serial test stream through a long series of equal-length shift-register segments and checks every bit that leaves the far end. It compares each outgoing bit with the bit that went in exactly one chain length earlier. An internal delay line of the same depth holds that earlier bit. In an irradiation setup this turns single-event upsets in the chain into a count that can be read out. The test is repeated at several clock rates to see how the error rate depends on frequency.

The stimulus comes from one of two sources. One is a 16-bit maximal-length LFSR and the other is a short fixed pattern that repeats. The pattern-select input picks the source. A start pulse begins a run, reloads both sources and clears the error state. A stop pulse freezes the chain, the sources and the comparison. Comparison stays off after each start until the chain has been filled once. The chain's tail bit is driven out on a serial port so it can be watched.

Top module: `shift_upset_top`

## Requirements
- R1: While running, `serial_o` equals the stimulus bit that was shifted in exactly DEPTH = SEG_LEN*SEG_COUNT shift cycles earlier. A shift cycle is a cycle with the run state set and neither `start_i` nor `stop_i` asserted.
- R2: With `pat_sel_i`=0 the stimulus bit is bit 15 of a 16-bit state. The state is loaded with SEED on start and advances on every shift cycle to {s[14:0], s[15]^s[13]^s[12]^s[10]}. The state is never zero.
- R3: With `pat_sel_i`=1 the stimulus bit is PATTERN[idx]. The index idx is 0 after start and steps by one on every shift cycle, wrapping after PAT_W-1. Both sources advance on every shift cycle whichever one is selected, so changing `pat_sel_i` during a run causes no errors.
- R4: After each start, no mismatch is counted until DEPTH shift cycles have elapsed.
- R5: Each shift cycle after the fill in which the chain tail differs from the delayed reference bit adds one to `err_cnt_o`. The count saturates at 2^CNT_W-1.
- R6: `err_flag_o` goes to 1 on the first counted mismatch and stays at 1 until the next start.
- R7: A start pulse clears the count and the flag, restarts the fill and reloads both sources. If `start_i` and `stop_i` are asserted together, start takes precedence.
- R8: After a stop the chain contents, `serial_o` and `err_cnt_o` hold their values, and mismatches are not counted until the next start.
- R9: After reset `err_cnt_o` is 0, `err_flag_o` is 0, `serial_o` is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a run |
| stop_i | input | 1 | One-cycle pulse that halts the run |
| pat_sel_i | input | 1 | 0 selects the LFSR, 1 selects the fixed pattern |
| serial_o | output | 1 | Bit at the chain tail |
| err_cnt_o | output | CNT_W | Saturating count of mismatches |
| err_flag_o | output | 1 | Sticky mismatch flag |

## Verification
The bench builds the block with SEG_LEN=8 and SEG_COUNT=4, which gives a 32-bit chain, and with CNT_W=4. With these values several full chain latencies fit into a short run, and the count's saturation at 15 can be reached with a small burst of injected upsets. Upsets are injected by forcing the chain's tail signal against the reference for a known number of cycles: during the fill, while stopped, and after the fill. The bench then compares the counts with the values it expects. A 32-bit chain still has four segment boundaries and an 8-bit pattern that does not divide the reference depth unevenly, so the segment links and the pattern wrap are exercised by the scoreboard.

// File: rtl/shift_upset_pkg.sv
package shift_upset_pkg;
  typedef enum logic {
    SRC_PRBS  = 1'b0,
    SRC_FIXED = 1'b1
  } src_e;

  localparam int unsigned LFSR_W = 16;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/upset_stim_gen.sv
module upset_stim_gen
  import shift_upset_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED    = 16'hACE1,
  parameter int unsigned       PAT_W   = 8,
  parameter logic [PAT_W-1:0]  PATTERN = 8'hCA
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  input  src_e sel_i,
  output logic bit_o
);
  localparam int unsigned IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

  logic [LFSR_W-1:0] lfsr_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= SEED;
      idx_q  <= '0;
    end else if (load_i) begin
      lfsr_q <= SEED;
      idx_q  <= '0;
    end else if (step_i) begin
      lfsr_q <= lfsr_step(lfsr_q);
      idx_q  <= (idx_q == IDX_W'(PAT_W - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign bit_o = (sel_i == SRC_FIXED) ? PATTERN[idx_q] : lfsr_q[LFSR_W-1];

  p_lfsr_nonzero_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  p_idx_range_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(PAT_W - 1));
endmodule

// File: rtl/upset_shift_chain.sv
module upset_shift_chain #(
  parameter int unsigned SEG_LEN   = 32,
  parameter int unsigned SEG_COUNT = 38
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic din_i,
  output logic dout_o
);
  logic [SEG_LEN-1:0] seg_q  [SEG_COUNT];
  logic               seg_in [SEG_COUNT];

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    if (g == 0) begin : g_head
      assign seg_in[g] = din_i;
    end else begin : g_link
      assign seg_in[g] = seg_q[g-1][SEG_LEN-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   seg_q[g] <= '0;
      else if (en_i) seg_q[g] <= {seg_q[g][SEG_LEN-2:0], seg_in[g]};
    end
  end

  assign dout_o = seg_q[SEG_COUNT-1][SEG_LEN-1];

  p_frozen_tail_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(seg_q[SEG_COUNT-1]));
endmodule

// File: rtl/upset_ref_delay.sv
module upset_ref_delay #(
  parameter int unsigned DEPTH = 1216
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic din_i,
  output logic dout_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic             ring_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (we_i) ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end

  // read-before-write: slot holds the bit written DEPTH writes ago
  always_ff @(posedge clk_i) begin
    if (we_i) ring_q[ptr_q] <= din_i;
  end

  assign dout_o = ring_q[ptr_q];

  p_ptr_range_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_W'(DEPTH - 1));
endmodule

// File: rtl/upset_err_tally.sv
module upset_err_tally #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      flag_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o  <= '0;
      flag_o <= 1'b0;
    end else if (hit_i) begin
      flag_o <= 1'b1;
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end

  p_no_overflow_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);

  p_sticky_flag_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  p_clear_on_start_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0 && !flag_o));
endmodule

// File: rtl/shift_upset_top.sv
module shift_upset_top
  import shift_upset_pkg::*;
#(
  parameter int unsigned       SEG_LEN   = 32,
  parameter int unsigned       SEG_COUNT = 38,
  parameter int unsigned       CNT_W     = 24,
  parameter logic [LFSR_W-1:0] SEED      = 16'hACE1,
  parameter int unsigned       PAT_W     = 8,
  parameter logic [PAT_W-1:0]  PATTERN   = 8'hCA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             pat_sel_i,
  output logic             serial_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             err_flag_o
);
  localparam int unsigned DEPTH  = SEG_LEN * SEG_COUNT;
  localparam int unsigned FILL_W = $clog2(DEPTH + 1);

  logic              run_q;
  logic [FILL_W-1:0] fill_q;
  logic              filled;
  logic              shift_en;
  logic              stim_bit;
  logic              chain_bit;
  logic              ref_bit;
  logic              hit;
  src_e              src_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
    else if (stop_i)  run_q <= 1'b0;
  end

  assign shift_en = run_q && !start_i && !stop_i;
  assign filled   = (fill_q == FILL_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   fill_q <= '0;
    else if (start_i)              fill_q <= '0;
    else if (shift_en && !filled)  fill_q <= fill_q + 1'b1;
  end

  assign src_sel = src_e'(pat_sel_i);

  upset_stim_gen #(
    .SEED   (SEED),
    .PAT_W  (PAT_W),
    .PATTERN(PATTERN)
  ) u_stim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start_i),
    .step_i(shift_en),
    .sel_i (src_sel),
    .bit_o (stim_bit)
  );

  upset_shift_chain #(
    .SEG_LEN  (SEG_LEN),
    .SEG_COUNT(SEG_COUNT)
  ) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .din_i (stim_bit),
    .dout_o(chain_bit)
  );

  upset_ref_delay #(
    .DEPTH(DEPTH)
  ) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (shift_en),
    .din_i (stim_bit),
    .dout_o(ref_bit)
  );

  assign hit = shift_en && filled && (chain_bit != ref_bit);

  upset_err_tally #(
    .CNT_W(CNT_W)
  ) u_tally (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_i),
    .hit_i (hit),
    .cnt_o (err_cnt_o),
    .flag_o(err_flag_o)
  );

  assign serial_o = chain_bit;

  p_fill_gate_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !filled) |=> $stable(err_cnt_o));

  p_idle_no_count_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> $stable(err_cnt_o));

  p_start_wins_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (run_q && fill_q == '0));
endmodule

// File: tb/shift_upset_top_test.sv
module shift_upset_top_test;
  localparam int unsigned SEG_LEN   = 8;
  localparam int unsigned SEG_COUNT = 4;
  localparam int unsigned DEPTH     = SEG_LEN * SEG_COUNT;
  localparam int unsigned CNT_W     = 4;
  localparam logic [15:0] SEED      = 16'hACE1;
  localparam int unsigned PAT_W     = 8;
  localparam logic [7:0]  PATTERN   = 8'hCA;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             stop_i = 1'b0;
  logic             pat_sel_i = 1'b0;
  logic             serial_o;
  logic [CNT_W-1:0] err_cnt_o;
  logic             err_flag_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  shift_upset_top #(
    .SEG_LEN(SEG_LEN), .SEG_COUNT(SEG_COUNT), .CNT_W(CNT_W),
    .SEED(SEED), .PAT_W(PAT_W), .PATTERN(PATTERN)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .stop_i(stop_i),
    .pat_sel_i(pat_sel_i), .serial_o(serial_o),
    .err_cnt_o(err_cnt_o), .err_flag_o(err_flag_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard model
  bit          sb_q[$];
  bit          m_run = 0;
  bit          inj = 0;
  int          shifted = 0;
  logic [15:0] m_lfsr = SEED;
  int          m_idx = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_i) begin
        sb_q.delete();
        shifted = 0;
        m_lfsr = SEED;
        m_idx = 0;
        m_run = 1;
      end else if (stop_i) begin
        m_run = 0;
      end else if (m_run) begin
        if (shifted >= DEPTH) begin
          bit exp_b;
          exp_b = sb_q.pop_front();
          if (!inj) check(pat_sel_i ? "R1 R3 tail bit" : "R1 R2 tail bit",
                          int'(serial_o), int'(exp_b));
        end
        sb_q.push_back(pat_sel_i ? PATTERN[m_idx] : m_lfsr[15]);
        shifted++;
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        m_idx = (m_idx == PAT_W - 1) ? 0 : m_idx + 1;
      end
    end
  end

  task automatic pulse(input bit st, input bit sp);
    @(posedge clk); #2;
    start_i = st; stop_i = sp;
    @(posedge clk); #2;
    start_i = 0; stop_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic inject(input int n);
    @(posedge clk); #2;
    inj = 1;
    force uut.chain_bit = ~uut.ref_bit;
    repeat (n) @(posedge clk);
    #2;
    release uut.chain_bit;
    inj = 0;
  endtask

  initial begin
    #(8 * 20000);
    n_fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic       held_bit;
    logic [3:0] held_cnt;
    idle(3);
    rst_n = 1;
    idle(2);
    // R9 reset state
    check("R9 count", int'(err_cnt_o), 0);
    check("R9 flag", int'(err_flag_o), 0);
    check("R9 serial", int'(serial_o), 0);

    // R2 LFSR run, clean
    pat_sel_i = 0;
    pulse(1, 0);
    idle(3 * DEPTH);
    check("R4 R5 clean LFSR count", int'(err_cnt_o), 0);

    // R3 switch sources mid-run
    pat_sel_i = 1;
    idle(2 * DEPTH + 3);
    pat_sel_i = 0;
    idle(DEPTH + 5);
    check("R3 no errors on source switch", int'(err_cnt_o), 0);
    check("R3 flag clear", int'(err_flag_o), 0);

    // R5 R6 upsets after fill
    inject(3);
    check("R5 count after 3 upsets", int'(err_cnt_o), 3);
    check("R6 flag set", int'(err_flag_o), 1);
    idle(10);
    check("R6 flag sticky", int'(err_flag_o), 1);

    // R8 stop holds
    pulse(0, 1);
    held_bit = serial_o;
    held_cnt = err_cnt_o;
    idle(5);
    check("R8 serial holds", int'(serial_o), int'(held_bit));
    inject(4);
    idle(2);
    check("R8 no count while stopped", int'(err_cnt_o), int'(held_cnt));
    check("R8 serial holds after", int'(serial_o), int'(held_bit));

    // R7 start and stop together, start wins
    pat_sel_i = 1;
    pulse(1, 1);
    check("R7 count cleared", int'(err_cnt_o), 0);
    check("R7 flag cleared", int'(err_flag_o), 0);
    // R4 upsets during fill are ignored
    inject(5);
    check("R4 no count during fill", int'(err_cnt_o), 0);
    check("R4 flag during fill", int'(err_flag_o), 0);
    idle(2 * DEPTH);
    check("R7 run resumed clean", int'(err_cnt_o), 0);

    // R5 saturation
    inject(20);
    check("R5 saturated", int'(err_cnt_o), 15);
    check("R6 flag after burst", int'(err_flag_o), 1);
    idle(DEPTH);
    check("R5 stays saturated", int'(err_cnt_o), 15);

    // R7 start clears again
    pulse(1, 0);
    check("R7 clear after saturation", int'(err_cnt_o), 0);
    check("R7 flag clear after saturation", int'(err_flag_o), 0);
    idle(DEPTH + 10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule